// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block stores each incoming frame in a ring of receive descriptors. The ring holds a power-of-two number of entries. Software hands an entry to the engine by writing the exact value 0x80 into its status byte. When a frame announcement arrives, the engine scans forward from its current ring position for such an entry. It writes the byte count into the descriptor, then the frame bytes into that entry's buffer. Last, it rewrites the status byte to 0x03. This one write returns the entry to software and marks it as holding both the start and the end of a packet. The receive-interrupt pulse is raised in the same cycle.

Descriptor memory lives outside the block. The engine reads status bytes through a combinational read port indexed by ring entry, and it writes through two byte-wide ports, one for descriptors and one for buffers. Each descriptor takes 8 bytes: the status byte sits at byte offset 2, and the 16-bit count sits at offsets 6 and 7 in swapped byte order. A frame is announced with a one-cycle strobe and its length. Its bytes then follow on a valid/ready byte stream. If no owned descriptor is found, the engine still consumes the frame bytes, discards them, and raises a one-cycle missed-frame pulse.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, both write enables, `rint` and `miss` are low, and the ring index is 0, so the first stored frame goes to entry 0.
- R2: Status-byte bits are: own 0x80, error 0x40, framing 0x20, overflow 0x10, CRC 0x08, buffer 0x04, start-of-packet 0x02, end-of-packet 0x01. An entry is taken only when its status byte equals exactly 0x80. Entries holding 0x81, 0xC0, 0x00 or 0x03 are skipped without any write to them.
- R3: The scan starts at the current index and wraps modulo the ring size. The entry just before the starting index (start−1 mod N) is never examined. If no entry qualifies, the frame is dropped.
- R4: The count written is the frame length plus 4. Its high byte goes to descriptor byte address idx·8+6 and its low byte to idx·8+7, in two consecutive cycles.
- R5: Frame byte n is written to buffer address idx·2^BUF_W + n, in arrival order. A cycle with `byte_valid` low writes nothing.
- R6: After the last data byte, the status byte at idx·8+2 is written with 0x03.
- R7: After a stored frame, the ring index advances by exactly one modulo N, whichever entry was used.
- R8: `rint` pulses for one cycle, in the same cycle as the status hand-back write.
- R9: A dropped frame causes no descriptor or buffer write. Its bytes are still consumed, `miss` pulses for one cycle, and the ring index is unchanged.
- R10: A zero-length frame writes count 4, makes no buffer write, and is still handed back.
- R11: For every stored frame, the writes come in this order: count high byte, count low byte, data bytes, status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle frame announcement, taken while idle |
| frm_len | input | BUF_W+1 | Frame length in bytes (at most 2^BUF_W) |
| byte_valid | input | 1 | Frame byte present |
| byte_data | input | 8 | Frame byte |
| data_rdy | output | 1 | Engine accepts a byte this cycle |
| busy | output | 1 | Engine is handling a frame |
| stat_rd_idx | output | IDX_W | Ring entry whose status byte is being read |
| stat_rd_data | input | 8 | Status byte of that entry (combinational) |
| desc_we | output | 1 | Descriptor byte write enable |
| desc_waddr | output | IDX_W+3 | Descriptor byte address |
| desc_wdata | output | 8 | Descriptor byte data |
| buf_we | output | 1 | Buffer byte write enable |
| buf_waddr | output | IDX_W+BUF_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| rint | output | 1 | Receive-interrupt pulse |
| miss | output | 1 | Missed-frame pulse |

## Verification
A wrong ring index or scan register shows at the ports right away: the first count write of the next frame lands on a different entry address. A wrong starting position shows too, because an owned entry just before the start would be used when it must be ignored. A wrong byte counter shows within the frame: buffer addresses shift, or the hand-back write and `rint` come a cycle early or late. A wrong skip or drop decision shows as a missing or unexpected `miss` pulse.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    // status byte bit meanings
    localparam logic [7:0] BIT_OWN  = 8'h80;
    localparam logic [7:0] BIT_ERR  = 8'h40;
    localparam logic [7:0] BIT_FRM  = 8'h20;
    localparam logic [7:0] BIT_OVF  = 8'h10;
    localparam logic [7:0] BIT_CRC  = 8'h08;
    localparam logic [7:0] BIT_BUF  = 8'h04;
    localparam logic [7:0] BIT_SOP  = 8'h02;
    localparam logic [7:0] BIT_EOP  = 8'h01;

    // exact value that hands an entry to the engine, and the hand-back value
    localparam logic [7:0] OWN_ONLY = BIT_OWN;
    localparam logic [7:0] HANDBACK = BIT_SOP | BIT_EOP;

    // byte offsets inside an 8-byte descriptor
    localparam logic [2:0] OFS_STAT   = 3'd2;
    localparam logic [2:0] OFS_CNT_HI = 3'd6;
    localparam logic [2:0] OFS_CNT_LO = 3'd7;

    localparam logic [15:0] CNT_PAD = 16'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CNTH,
        ST_CNTL,
        ST_DATA,
        ST_HAND,
        ST_DROP
    } rx_state_e;

    function automatic logic [15:0] rx_count(input logic [15:0] len);
        return len + CNT_PAD;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic             adv,
    output logic [IDX_W-1:0] cur,
    output logic [IDX_W-1:0] scan,
    output logic             scan_last
);
    logic [IDX_W-1:0] scan_nx;
    logic [IDX_W-1:0] stop_idx;

    always_comb begin
        scan_nx  = scan + IDX_W'(1);
        stop_idx = cur - IDX_W'(1);
        // no further entry remains once the next one would be start-1
        scan_last = (scan_nx == stop_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            scan <= '0;
        end else begin
            if (adv)
                cur <= cur + IDX_W'(1);
            if (load)
                scan <= cur;
            else if (step)
                scan <= scan_nx;
        end
    end
endmodule

// File: rtl/rxr_byte_cnt.sv
module rxr_byte_cnt #(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    input  logic             inc,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] len_q,
    output logic             done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt   <= '0;
            len_q <= len_in;
        end else if (inc) begin
            cnt <= cnt + LEN_W'(1);
        end
    end

    assign done = (cnt == len_q);
endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import rxr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_valid,
    input  logic [7:0] stat_rd_data,
    input  logic      scan_last,
    input  logic      done,
    input  logic      byte_valid,
    output rx_state_e state,
    output logic      load,
    output logic      step,
    output logic      adv,
    output logic      take
);
    rx_state_e state_nx;
    logic      own_hit;

    always_comb begin
        own_hit  = (stat_rd_data == OWN_ONLY);
        load     = 1'b0;
        step     = 1'b0;
        adv      = 1'b0;
        take     = 1'b0;
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (frm_valid) begin
                    load     = 1'b1;
                    state_nx = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (own_hit)
                    state_nx = ST_CNTH;
                else if (scan_last)
                    state_nx = ST_DROP;
                else
                    step = 1'b1;
            end
            ST_CNTH: state_nx = ST_CNTL;
            ST_CNTL: state_nx = ST_DATA;
            ST_DATA: begin
                if (done)
                    state_nx = ST_HAND;
                else
                    take = byte_valid;
            end
            ST_HAND: begin
                adv      = 1'b1;
                state_nx = ST_IDLE;
            end
            ST_DROP: begin
                if (done)
                    state_nx = ST_IDLE;
                else
                    take = byte_valid;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end
endmodule

// File: rtl/rxr_wport.sv
module rxr_wport
    import rxr_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int BUF_W = 9,
    parameter int LEN_W = 10
) (
    input  rx_state_e              state,
    input  logic [IDX_W-1:0]       scan,
    input  logic [LEN_W-1:0]       cnt,
    input  logic [LEN_W-1:0]       len_q,
    input  logic                   done,
    input  logic                   take,
    input  logic [7:0]             byte_data,
    output logic                   desc_we,
    output logic [IDX_W+2:0]       desc_waddr,
    output logic [7:0]             desc_wdata,
    output logic                   buf_we,
    output logic [IDX_W+BUF_W-1:0] buf_waddr,
    output logic [7:0]             buf_wdata,
    output logic                   rint,
    output logic                   miss,
    output logic                   data_rdy,
    output logic                   busy
);
    logic [15:0] cnt16;
    logic [2:0]  ofs;

    always_comb begin
        cnt16      = rx_count(16'(len_q));
        desc_we    = 1'b0;
        desc_wdata = 8'h00;
        ofs        = OFS_STAT;
        unique case (state)
            ST_CNTH: begin
                desc_we    = 1'b1;
                ofs        = OFS_CNT_HI;
                desc_wdata = cnt16[15:8];
            end
            ST_CNTL: begin
                desc_we    = 1'b1;
                ofs        = OFS_CNT_LO;
                desc_wdata = cnt16[7:0];
            end
            ST_HAND: begin
                desc_we    = 1'b1;
                ofs        = OFS_STAT;
                desc_wdata = HANDBACK;
            end
            default: ;
        endcase
        desc_waddr = {scan, ofs};
    end

    assign buf_we    = take && (state == ST_DATA);
    assign buf_waddr = {scan, cnt[BUF_W-1:0]};
    assign buf_wdata = byte_data;
    assign rint      = (state == ST_HAND);
    assign miss      = (state == ST_DROP) && done;
    assign data_rdy  = ((state == ST_DATA) || (state == ST_DROP)) && !done;
    assign busy      = (state != ST_IDLE);
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
    import rxr_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int BUF_W = 9,
    localparam int LEN_W = BUF_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frm_valid,
    input  logic [LEN_W-1:0]       frm_len,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_data,
    output logic                   data_rdy,
    output logic                   busy,
    output logic [IDX_W-1:0]       stat_rd_idx,
    input  logic [7:0]             stat_rd_data,
    output logic                   desc_we,
    output logic [IDX_W+2:0]       desc_waddr,
    output logic [7:0]             desc_wdata,
    output logic                   buf_we,
    output logic [IDX_W+BUF_W-1:0] buf_waddr,
    output logic [7:0]             buf_wdata,
    output logic                   rint,
    output logic                   miss
);
    rx_state_e        state;
    logic             load, step, adv, take;
    logic [IDX_W-1:0] cur, scan;
    logic             scan_last;
    logic [LEN_W-1:0] cnt, len_q;
    logic             done;

    rxr_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .frm_valid    (frm_valid),
        .stat_rd_data (stat_rd_data),
        .scan_last    (scan_last),
        .done         (done),
        .byte_valid   (byte_valid),
        .state        (state),
        .load         (load),
        .step         (step),
        .adv          (adv),
        .take         (take)
    );

    rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .step      (step),
        .adv       (adv),
        .cur       (cur),
        .scan      (scan),
        .scan_last (scan_last)
    );

    rxr_byte_cnt #(.LEN_W(LEN_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .len_in (frm_len),
        .inc    (take),
        .cnt    (cnt),
        .len_q  (len_q),
        .done   (done)
    );

    rxr_wport #(.IDX_W(IDX_W), .BUF_W(BUF_W), .LEN_W(LEN_W)) u_wp (
        .state      (state),
        .scan       (scan),
        .cnt        (cnt),
        .len_q      (len_q),
        .done       (done),
        .take       (take),
        .byte_data  (byte_data),
        .desc_we    (desc_we),
        .desc_waddr (desc_waddr),
        .desc_wdata (desc_wdata),
        .buf_we     (buf_we),
        .buf_waddr  (buf_waddr),
        .buf_wdata  (buf_wdata),
        .rint       (rint),
        .miss       (miss),
        .data_rdy   (data_rdy),
        .busy       (busy)
    );

    assign stat_rd_idx = scan;
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             desc_we,
    input logic [IDX_W+2:0] desc_waddr,
    input logic [7:0]       desc_wdata,
    input logic             buf_we,
    input logic             rint,
    input logic             miss
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!desc_we && !buf_we && !rint && !miss));

    // R6
    handback_val_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_we && desc_waddr[2:0] == 3'd2) |-> (desc_wdata == 8'h03));

    // R8
    rint_with_hand_chk: assert property (@(posedge clk) disable iff (rst)
        rint |-> (desc_we && desc_waddr[2:0] == 3'd2));

    // R8
    rint_single_chk: assert property (@(posedge clk) disable iff (rst)
        rint |=> !rint);

    // R9
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        miss |-> (!desc_we && !buf_we && !rint));

    // R9
    miss_single_chk: assert property (@(posedge clk) disable iff (rst)
        miss |=> (!miss && !busy));

    // R4
    cnt_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_we && desc_waddr[2:0] == 3'd6) |=>
        (desc_we && desc_waddr[2:0] == 3'd7 &&
         desc_waddr[IDX_W+2:3] == $past(desc_waddr[IDX_W+2:3])));

    // R11
    data_excl_chk: assert property (@(posedge clk) disable iff (rst)
        buf_we |-> !desc_we);
endmodule

bind rx_ring_engine rxr_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .desc_we    (desc_we),
    .desc_waddr (desc_waddr),
    .desc_wdata (desc_wdata),
    .buf_we     (buf_we),
    .rint       (rint),
    .miss       (miss)
);

// File: tb/sim_rx_ring_engine.sv
module sim_rx_ring_engine;
    localparam int IDX_W = 3;
    localparam int BUF_W = 9;
    localparam int LEN_W = BUF_W + 1;
    localparam int NENT  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic                   frm_valid = 1'b0;
    logic [LEN_W-1:0]       frm_len = '0;
    logic                   byte_valid = 1'b0;
    logic [7:0]             byte_data = 8'h00;
    logic                   data_rdy, busy;
    logic [IDX_W-1:0]       stat_rd_idx;
    logic [7:0]             stat_rd_data;
    logic                   desc_we, buf_we, rint, miss;
    logic [IDX_W+2:0]       desc_waddr;
    logic [7:0]             desc_wdata, buf_wdata;
    logic [IDX_W+BUF_W-1:0] buf_waddr;

    logic [7:0] stat_mem [NENT];
    assign stat_rd_data = stat_mem[stat_rd_idx];

    rx_ring_engine #(.IDX_W(IDX_W), .BUF_W(BUF_W)) u0 (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_len(frm_len),
        .byte_valid(byte_valid), .byte_data(byte_data), .data_rdy(data_rdy),
        .busy(busy), .stat_rd_idx(stat_rd_idx), .stat_rd_data(stat_rd_data),
        .desc_we(desc_we), .desc_waddr(desc_waddr), .desc_wdata(desc_wdata),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .rint(rint), .miss(miss)
    );

    typedef struct {
        int    kind;   // 0 desc write, 1 buffer write, 2 rint, 3 miss
        int    addr;
        int    data;
        string req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    int model_cur = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data, input string req);
        exp_t e;
        e.kind = kind; e.addr = addr; e.data = data; e.req = req;
        q.push_back(e);
    endtask

    task automatic observe(input int kind, input int addr, input int data);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "R9/R2 unexpected event", kind * 65536 + addr, -1);
        end else begin
            e = q.pop_front();
            check(e.kind == kind && e.addr == addr && e.data == data, e.req,
                  kind * 16777216 + addr * 256 + data,
                  e.kind * 16777216 + e.addr * 256 + e.data);
        end
    endtask

    // monitor: compare writes and pulses, and keep the status bytes up to date
    always @(negedge clk) begin
        if (!rst) begin
            if (desc_we) begin
                observe(0, int'(desc_waddr), int'(desc_wdata));
                if (desc_waddr[2:0] == 3'd2)
                    stat_mem[desc_waddr[IDX_W+2:3]] = desc_wdata;
            end
            if (buf_we)
                observe(1, int'(buf_waddr), int'(buf_wdata));
            if (rint)
                observe(2, 0, 0);
            if (miss)
                observe(3, 0, 0);
        end
    end

    function automatic logic [7:0] pat(input int n, input int seed);
        return 8'((n * 7 + seed) & 255);
    endfunction

    task automatic send_frame(input int len, input int seed, input bit gapped);
        int start, i, found, cnt, k;
        start = model_cur;
        found = -1;
        i = start;
        // R3: examine from start, stop before start-1
        while (i != ((start + NENT - 1) % NENT)) begin
            if (stat_mem[i] == 8'h80) begin   // R2 exact match
                found = i;
                break;
            end
            i = (i + 1) % NENT;
        end
        if (found < 0) begin
            push(3, 0, 0, "R9 miss pulse");
        end else begin
            cnt = len + 4;
            push(0, found * 8 + 6, (cnt >> 8) & 255, "R4 count high byte");
            push(0, found * 8 + 7, cnt & 255, "R4 count low byte");
            for (int n = 0; n < len; n++)
                push(1, found * (1 << BUF_W) + n, int'(pat(n, seed)), "R5 data byte");
            push(0, found * 8 + 2, 8'h03, "R6 status handback");
            push(2, 0, 0, "R8 rint pulse");
            model_cur = (model_cur + 1) % NENT;   // R7
        end
        @(negedge clk);
        frm_valid = 1'b1;
        frm_len   = LEN_W'(len);
        @(negedge clk);
        frm_valid = 1'b0;
        i = 0;
        k = 0;
        while (i < len) begin
            byte_valid = !(gapped && (k % 3 == 1));
            byte_data  = pat(i, seed);
            if (byte_valid && data_rdy)
                i++;
            k++;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        check(q.size() == 0, "R11 all expected writes seen", q.size(), 0);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        report();
        $finish;
    end

    initial begin
        for (int e = 0; e < NENT; e++) stat_mem[e] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        repeat (2) @(negedge clk);
        check(!busy && !desc_we && !buf_we && !rint && !miss, "R1 idle after reset",
              {busy, desc_we, buf_we, rint, miss}, 0);

        // R1: two owned entries, index 0 must be chosen
        stat_mem[0] = 8'h80;
        stat_mem[1] = 8'h80;
        send_frame(5, 1, 1'b0);
        stat_mem[1] = 8'h00;

        // R2: skip 0x81 and 0xC0, take 0x80 at entry 3; R7 index -> 2
        stat_mem[1] = 8'h81;
        stat_mem[2] = 8'hC0;
        stat_mem[3] = 8'h80;
        send_frame(3, 9, 1'b0);

        // R7: scan restarts at 2, entry 3 now 0x03, entry 4 owned
        stat_mem[4] = 8'h80;
        send_frame(17, 33, 1'b1);

        // R10: zero-length frame into entry 5
        stat_mem[5] = 8'h80;
        send_frame(0, 0, 1'b0);

        // R9: nothing owned, frame dropped, bytes consumed
        send_frame(4, 2, 1'b1);

        // R3: only entry start-1 (3) owned: never examined -> drop
        stat_mem[3] = 8'h80;
        send_frame(2, 5, 1'b0);
        // R3: wrap to entry 2 (start-2)
        stat_mem[3] = 8'h00;
        stat_mem[2] = 8'h80;
        send_frame(6, 11, 1'b0);

        // R4: count above 255, long gapped frame into entry 7
        stat_mem[7] = 8'h80;
        send_frame(300, 77, 1'b1);

        // R9 index unchanged after miss then use; R5 full buffer
        stat_mem[6] = 8'h80;
        send_frame(512, 3, 1'b0);

        check(q.size() == 0, "R11 queue drained", q.size(), 0);
        report();
        $finish;
    end
endmodule